// File: doc/BRIEF.md
# Two-Rectangle Haar Feature Multiply-Accumulate Engine

This engine evaluates one two-rectangle Haar-like feature over a small integral-image window. A caller pulses `start` with eight corner addresses and a signed fixed-point scale factor. The block then reads the eight integral values one per cycle from a synchronous RAM port.

Each value is multiplied by a signed weight chosen from the corner's position. The weight is ±1 for the first rectangle and ±scale for the second. A single multiplier and a single accumulator do all the work. The full-precision signed result appears on `feat_out`, together with a one-cycle `done` strobe.

Corners are indexed 0..7 and named A, B, C, D (first rectangle) and E, F, G, H (second rectangle). The first rectangle's sum is A + D − B − C. The second rectangle's sum is E + H − F − G. The engine returns scale × (second sum) − (first sum). Threshold comparison and classifier weighting are done downstream.

Top module: `haar_feature_mac`

## Requirements
- R1: While `rst` is high and after it falls, with no start, `done` is 0, `ram_en` is 0 and `feat_out` is 0.
- R2: A start sampled at edge k drives `ram_en` high for exactly the 8 cycles after edges k..k+7. `ram_addr` presents corner slots 0 through 7 in that order. Slot i is bits [i*ADDR_W +: ADDR_W] of `corner_addr`.
- R3: The weights are applied by slot and then summed. The weights are: slot 0 (A) −1, slot 1 (B) +1, slot 2 (C) +1, slot 3 (D) −1, slot 4 (E) +scale, slot 5 (F) −scale, slot 6 (G) −scale, slot 7 (H) +scale. Here 1.0 is 4096, and the result carries 12 fractional bits.
- R4: `done` is high for exactly one cycle, after edge k+9. In that cycle `feat_out` holds the new result.
- R5: `feat_out` keeps its value in every cycle in which `done` is low.
- R6: `corner_addr` and `coeff` are captured at the accepted start. Changes to them, and any start pulse while a feature is in progress, have no effect on the addresses issued or on the result.
- R7: The result is exact with no overflow for any 18-bit unsigned integral values and any 16-bit signed scale, including −32768.
- R8: Each feature starts from a cleared accumulator, so no earlier feature leaks into its result.
- R9: A start presented in the cycle where `done` is high is accepted. Its result follows 9 edges later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a feature evaluation (ignored while busy) |
| corner_addr | input | 8*ADDR_W | Eight corner addresses, slot 0 in the low bits |
| coeff | input | COEF_W | Signed scale, 12 fractional bits |
| ram_addr | output | ADDR_W | Integral-image RAM read address |
| ram_en | output | 1 | RAM read enable; data returns one cycle later |
| ram_data | input | DATA_W | Integral value read from RAM |
| feat_out | output | ACC_W | Signed feature value, 12 fractional bits |
| done | output | 1 | One-cycle result strobe |

## Verification
The bench gives every corner a distinct value and a distinct address, spread in reverse order. A design that swapped weights, mixed up sign bits or mis-ordered the slots would therefore return a wrong sum or issue a wrong address.

It drives full-scale integral values together with the most negative scale. This exposes a weight negation that overflows or an accumulator that is too narrow.

Three further cases target specific faults:
- A stray start and a changed scale are injected mid-run. A design that restarted or re-read its inputs would corrupt the result or the address sequence.
- A start is placed in the done cycle itself. A design with an off-by-one busy window would drop that start.
- An idle stretch follows each result. A design that failed to hold the result register would let `feat_out` drift.

// File: rtl/haar_mac_pkg.sv
package haar_mac_pkg;

    localparam int N_CORNER = 8;
    localparam int IDX_W    = $clog2(N_CORNER);

    typedef enum logic [IDX_W-1:0] {
        CRN_A, CRN_B, CRN_C, CRN_D, CRN_E, CRN_F, CRN_G, CRN_H
    } corner_e;

    // Weight selector: scaled picks coeff instead of unity, neg flips sign.
    typedef struct packed {
        logic neg;
        logic scaled;
    } wsel_t;

    // Upper index bit picks the rectangle; the two low bits decide the sign.
    function automatic wsel_t corner_sel(input int unsigned i);
        logic [IDX_W-1:0] b;
        wsel_t s;
        b        = IDX_W'(i);
        s.scaled = b[2];
        s.neg    = b[2] ^ ~(b[1] ^ b[0]);
        return s;
    endfunction

    function automatic int acc_width(input int data_w, input int coef_w);
        return data_w + coef_w + 2 + IDX_W;
    endfunction

endpackage

// File: rtl/haar_seq.sv
module haar_seq
    import haar_mac_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       start_i,
    input  logic [N_CORNER*ADDR_W-1:0] corner_addr_i,
    output logic [ADDR_W-1:0]          ram_addr_o,
    output logic                       ram_en_o,
    output logic                       go_o,
    output logic                       rd_vld_o,
    output corner_e                    rd_idx_o
);

    logic              iss_q;
    corner_e           idx_q;
    logic              busy;
    logic [ADDR_W-1:0] addr_q [N_CORNER];

    assign busy = iss_q | rd_vld_o;
    assign go_o = start_i & ~busy;

    generate
        for (genvar g = 0; g < N_CORNER; g++) begin : g_slot
            always_ff @(posedge clk) begin
                if (rst)       addr_q[g] <= '0;
                else if (go_o) addr_q[g] <= corner_addr_i[g*ADDR_W +: ADDR_W];
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            iss_q    <= 1'b0;
            idx_q    <= CRN_A;
            rd_vld_o <= 1'b0;
            rd_idx_o <= CRN_A;
        end else begin
            rd_vld_o <= iss_q;
            rd_idx_o <= idx_q;
            if (go_o) begin
                iss_q <= 1'b1;
                idx_q <= CRN_A;
            end else if (iss_q) begin
                if (idx_q == CRN_H) iss_q <= 1'b0;
                idx_q <= corner_e'(idx_q + 1'b1);
            end
        end
    end

    assign ram_en_o   = iss_q;
    assign ram_addr_o = addr_q[idx_q];

    // R2: slots are issued in ascending order on consecutive cycles
    p_order_r2: assert property (@(posedge clk) disable iff (rst)
        (iss_q && idx_q != CRN_H) |=> (iss_q && idx_q == corner_e'($past(idx_q) + 1'b1)));

    // R2: issue stops after the last slot
    p_stop_r2: assert property (@(posedge clk) disable iff (rst)
        (iss_q && idx_q == CRN_H) |=> !iss_q);

    // R6: a start while busy neither restarts the walk nor reloads addresses
    p_start_ignored_r6: assert property (@(posedge clk) disable iff (rst)
        (start_i && iss_q && idx_q != CRN_H) |=> (idx_q != CRN_A && $stable(addr_q[0])));

    // R2: every issued read returns as a valid beat one cycle later
    p_rd_follow_r2: assert property (@(posedge clk) disable iff (rst)
        ram_en_o |=> rd_vld_o);

endmodule

// File: rtl/haar_wsel.sv
module haar_wsel
    import haar_mac_pkg::*;
#(
    parameter int COEF_W = 16,
    parameter int FRAC_W = 12
) (
    input  corner_e                  idx_i,
    input  logic signed [COEF_W-1:0] coeff_i,
    output logic signed [COEF_W:0]   weight_o
);

    localparam int WW = COEF_W + 1;
    localparam logic signed [WW-1:0] UNITY =
        {{(WW-FRAC_W-1){1'b0}}, 1'b1, {FRAC_W{1'b0}}};

    logic signed [WW-1:0] cext;
    logic signed [WW-1:0] wt [N_CORNER];

    assign cext = {coeff_i[COEF_W-1], coeff_i};

    generate
        for (genvar g = 0; g < N_CORNER; g++) begin : g_wt
            localparam wsel_t S = corner_sel(g);
            if (S.scaled) begin : g_scl
                assign wt[g] = S.neg ? -cext : cext;
            end else begin : g_unit
                assign wt[g] = S.neg ? -UNITY : UNITY;
            end
        end
    endgenerate

    assign weight_o = wt[idx_i];

endmodule

// File: rtl/haar_acc.sv
module haar_acc
    import haar_mac_pkg::*;
#(
    parameter int DATA_W = 18,
    parameter int COEF_W = 16,
    parameter int FRAC_W = 12,
    parameter int ACC_W  = acc_width(DATA_W, COEF_W)
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     go_i,
    input  logic signed [COEF_W-1:0] coeff_i,
    input  logic                     rd_vld_i,
    input  corner_e                  rd_idx_i,
    input  logic [DATA_W-1:0]        rd_data_i,
    output logic signed [ACC_W-1:0]  feat_o,
    output logic                     done_o
);

    localparam int PROD_W = DATA_W + 1 + COEF_W + 1;

    logic signed [COEF_W-1:0] coeff_q;
    logic signed [COEF_W:0]   weight;
    logic signed [PROD_W-1:0] prod;
    logic signed [ACC_W-1:0]  pext;
    logic signed [ACC_W-1:0]  acc_q;

    always_ff @(posedge clk) begin
        if (rst)       coeff_q <= '0;
        else if (go_i) coeff_q <= coeff_i;
    end

    haar_wsel #(
        .COEF_W (COEF_W),
        .FRAC_W (FRAC_W)
    ) u_wsel (
        .idx_i    (rd_idx_i),
        .coeff_i  (coeff_q),
        .weight_o (weight)
    );

    assign prod = $signed({1'b0, rd_data_i}) * weight;
    assign pext = {{(ACC_W-PROD_W){prod[PROD_W-1]}}, prod};

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q  <= '0;
            feat_o <= '0;
            done_o <= 1'b0;
        end else begin
            done_o <= 1'b0;
            if (go_i) begin
                acc_q <= '0;
            end else if (rd_vld_i) begin
                if (rd_idx_i == CRN_H) begin
                    feat_o <= acc_q + pext;
                    acc_q  <= '0;
                    done_o <= 1'b1;
                end else begin
                    acc_q <= acc_q + pext;
                end
            end
        end
    end

    // R4: the strobe never lasts two cycles
    p_done_pulse_r4: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    // R4: the strobe follows the beat carrying the last corner
    p_done_src_r4: assert property (@(posedge clk) disable iff (rst)
        done_o |-> $past(rd_vld_i && rd_idx_i == CRN_H));

    // R5: the result only moves with the strobe
    p_hold_r5: assert property (@(posedge clk) disable iff (rst)
        !done_o |-> $stable(feat_o));

    // R8: the first corner of a feature meets an empty accumulator
    p_first_clear_r8: assert property (@(posedge clk) disable iff (rst)
        (rd_vld_i && rd_idx_i == CRN_A) |-> acc_q == '0);

    // R6: the captured scale does not change during a feature
    p_coeff_held_r6: assert property (@(posedge clk) disable iff (rst)
        rd_vld_i |=> $stable(coeff_q));

endmodule

// File: rtl/haar_feature_mac.sv
module haar_feature_mac
    import haar_mac_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 18,
    parameter int COEF_W = 16,
    parameter int FRAC_W = 12,
    parameter int ACC_W  = acc_width(DATA_W, COEF_W)
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       start,
    input  logic [N_CORNER*ADDR_W-1:0] corner_addr,
    input  logic signed [COEF_W-1:0]   coeff,
    output logic [ADDR_W-1:0]          ram_addr,
    output logic                       ram_en,
    input  logic [DATA_W-1:0]          ram_data,
    output logic signed [ACC_W-1:0]    feat_out,
    output logic                       done
);

    logic    go;
    logic    rd_vld;
    corner_e rd_idx;

    haar_seq #(
        .ADDR_W (ADDR_W)
    ) u_seq (
        .clk           (clk),
        .rst           (rst),
        .start_i       (start),
        .corner_addr_i (corner_addr),
        .ram_addr_o    (ram_addr),
        .ram_en_o      (ram_en),
        .go_o          (go),
        .rd_vld_o      (rd_vld),
        .rd_idx_o      (rd_idx)
    );

    haar_acc #(
        .DATA_W (DATA_W),
        .COEF_W (COEF_W),
        .FRAC_W (FRAC_W),
        .ACC_W  (ACC_W)
    ) u_acc (
        .clk       (clk),
        .rst       (rst),
        .go_i      (go),
        .coeff_i   (coeff),
        .rd_vld_i  (rd_vld),
        .rd_idx_i  (rd_idx),
        .rd_data_i (ram_data),
        .feat_o    (feat_out),
        .done_o    (done)
    );

    // R1: nothing is read or reported without an accepted start
    p_idle_r1: assert property (@(posedge clk) disable iff (rst)
        (!ram_en && !rd_vld && !go) |=> !ram_en);

endmodule

// File: tb/haar_feature_mac_bench.sv
`timescale 1ns/1ps
module haar_feature_mac_bench;

    localparam int ADDR_W = 10;
    localparam int DATA_W = 18;
    localparam int COEF_W = 16;
    localparam int ACC_W  = DATA_W + COEF_W + 5;
    localparam int NV     = 7;
    localparam int MAXV   = 262143;

    // corner values in slot order A,B,C,D,E,F,G,H, and scale per vector
    localparam int VAL [NV][8] = '{
        '{10, 20, 30, 40, 50, 60, 70, 80},
        '{100, 0, 0, 0, 0, 0, 0, 0},
        '{0, 500, 700, 0, 0, 0, 0, 0},
        '{5, 6, 7, 8, 1000, 300, 400, 2000},
        '{0, MAXV, MAXV, 0, MAXV, 0, 0, MAXV},
        '{MAXV, 0, 0, MAXV, 0, MAXV, MAXV, 0},
        '{123, 4567, 89, 1011, 1213, 14151, 617, 18192}
    };
    localparam int CF [NV] = '{8192, 12288, 10240, 11264, 32767, -32768, -4096};

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    logic [8*ADDR_W-1:0] corner_addr = '0;
    logic signed [COEF_W-1:0] coeff = '0;
    logic [ADDR_W-1:0] ram_addr;
    logic ram_en;
    logic [DATA_W-1:0] ram_data = '0;
    logic signed [ACC_W-1:0] feat_out;
    logic done;

    logic [DATA_W-1:0] mem [1024];
    int n_run = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    always @(posedge clk) if (ram_en) ram_data <= mem[ram_addr];

    haar_feature_mac u_haar_feature_mac (
        .clk         (clk),
        .rst         (rst),
        .start       (start),
        .corner_addr (corner_addr),
        .coeff       (coeff),
        .ram_addr    (ram_addr),
        .ram_en      (ram_en),
        .ram_data    (ram_data),
        .feat_out    (feat_out),
        .done        (done)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int adr_of(input int v, input int i);
        return 37 * v + 3 + 5 * (7 - i);
    endfunction

    function automatic longint exp_of(input int v);
        longint s1, s2;
        s1 = longint'(VAL[v][0]) + VAL[v][3] - VAL[v][1] - VAL[v][2];
        s2 = longint'(VAL[v][4]) + VAL[v][7] - VAL[v][5] - VAL[v][6];
        return longint'(CF[v]) * s2 - 64'sd4096 * s1;
    endfunction

    task automatic load_vec(input int v);
        for (int i = 0; i < 8; i++) mem[adr_of(v, i)] = DATA_W'(VAL[v][i]);
    endtask

    task automatic drive_vec(input int v);
        for (int i = 0; i < 8; i++) corner_addr[i*ADDR_W +: ADDR_W] = ADDR_W'(adr_of(v, i));
        coeff = COEF_W'(CF[v]);
        start = 1'b1;
    endtask

    // Assumes start already driven at a negedge; walks edges k..k+10.
    // chain >= 0 starts that vector in the done cycle (R9).
    task automatic walk(input int v, input bit inject, input int chain);
        bit en_ok = 1'b1, adr_ok = 1'b1, dn_ok = 1'b1;
        @(posedge clk);
        for (int j = 0; j <= 10; j++) begin
            @(negedge clk);
            if (j <= 7) begin
                if (!ram_en) en_ok = 1'b0;
                if (ram_addr != ADDR_W'(adr_of(v, j))) begin
                    adr_ok = 1'b0;
                    $display("FAIL R2 slot %0d addr actual=%0d expected=%0d", j, ram_addr, adr_of(v, j));
                end
            end else if (ram_en && !(chain >= 0 && j == 10)) en_ok = 1'b0;
            if (j == 9) begin
                if (!done) dn_ok = 1'b0;
                chk(longint'(feat_out) == exp_of(v), (v >= 4) ? "R7 R3 result" : "R3 result",
                    longint'(feat_out), exp_of(v));
            end else if (j < 10 && done) dn_ok = 1'b0;
            start = 1'b0;
            if (inject && j == 3) begin
                start = 1'b1;
                coeff = -16'sd1;
                corner_addr = '1;
            end
            if (chain >= 0 && j == 9) begin
                drive_vec(chain);
                return;
            end
        end
        chk(en_ok, "R2 ram_en window", en_ok, 1);
        chk(adr_ok, inject ? "R6 R2 address order" : "R2 address order", adr_ok, 1);
        chk(dn_ok, "R4 done timing", dn_ok, 1);
    endtask

    initial begin
        for (int a = 0; a < 1024; a++) mem[a] = '0;
        repeat (3) @(negedge clk);
        chk(done == 1'b0, "R1 done in reset", done, 0);
        chk(ram_en == 1'b0, "R1 ram_en in reset", ram_en, 0);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        chk(done == 1'b0 && ram_en == 1'b0, "R1 idle after reset", {done, ram_en}, 0);
        chk(feat_out == '0, "R1 result after reset", longint'(feat_out), 0);

        // table walk; each run follows a different previous result (R8)
        for (int v = 0; v < NV; v++) begin
            load_vec(v);
            @(negedge clk);
            drive_vec(v);
            walk(v, v == 2, -1);
            if (v == 1) chk(longint'(feat_out) == exp_of(1), "R8 no leak from previous", longint'(feat_out), exp_of(1));
        end

        // R5: result holds through idle cycles
        repeat (6) @(negedge clk);
        chk(longint'(feat_out) == exp_of(NV-1) && !done, "R5 hold while idle",
            longint'(feat_out), exp_of(NV-1));

        // R9: back-to-back, second start in the done cycle
        load_vec(0);
        load_vec(3);
        @(negedge clk);
        drive_vec(0);
        walk(0, 1'b0, 3);
        walk(3, 1'b0, -1);
        chk(longint'(feat_out) == exp_of(3), "R9 back-to-back result", longint'(feat_out), exp_of(3));

        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule